// File: doc/BRIEF.md
# Full-Map Home Directory Controller

This block is the home-node coherence engine for a group of processors that share memory. For every memory block it keeps a presence vector (one bit per processor) and a single modified flag, and it holds the block's memory word itself. A processor that misses in its cache sends a read-miss or write-miss request naming the block and its own index. The controller decides from the directory entry whether memory can answer at once, or whether other caches must first give up or hand back their copies.

When other caches must act, the controller issues one outbound message. That message carries a destination mask, so all sharers of a block are invalidated in the same cycle. It then collects one response per targeted processor. A recalled dirty line is written back into memory before the requester receives it. Read-miss replies grant shared permission and write-miss replies grant exclusive permission. When a reply is sent, the directory entry is rewritten to match the new sharing state. The engine handles one transaction at a time, so a request that arrives while a transaction is open waits at the request port.

Top module: `dir_ctrl`

## Requirements
- R1: After reset the controller is idle: req_ready is 1, msg_valid and rpl_valid are 0, every presence vector and modified flag is clear, and the memory word of block b holds b+16.
- R2: A read miss to a clean block sends no message, and the reply (rpl_excl 0, the memory word) appears in the cycle after the request is accepted. The requester's presence bit is then set.
- R3: A read miss to a modified block sends one message of type 1 (recall-to-shared) whose destination mask has only the owner's bit. The reply carries the data returned in the owner's response, and memory takes that data. The modified flag is cleared, and both the owner and the requester are then present.
- R4: A write miss to a clean block with other sharers sends one message of type 3 (invalidate) whose destination mask equals the presence vector minus the requester's bit. With no other sharers, no message is sent and the reply follows the acceptance by one cycle.
- R5: The reply to a message-bearing request appears only in the cycle after the response from the last still-pending destination. Responses from processors that are not pending are ignored.
- R6: After a write-miss reply, the block is modified and the requester is its only present processor.
- R7: A write miss to a block modified by another processor sends one message of type 2 (recall-and-invalidate) to the owner only. The reply carries the owner's returned data, and memory takes that data.
- R8: req_ready is 0 from the cycle after an acceptance through the reply cycle, and is 1 again in the cycle after the reply.
- R9: Each reply carries rpl_pid equal to the requester index and rpl_excl equal to 1 for write misses and 0 for read misses. Message type 0 never appears with msg_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| req_blk | input | BW | Block index |
| req_pid | input | PW | Requesting processor index |
| msg_valid | output | 1 | Outbound coherence message valid |
| msg_type | output | 2 | 1 recall-to-shared, 2 recall-and-invalidate, 3 invalidate |
| msg_dst | output | NPROC | Destination mask, one bit per processor |
| rsp_valid | input | 1 | Response from a cache |
| rsp_pid | input | PW | Responding processor index |
| rsp_data | input | DW | Line data returned by a recall response |
| rpl_valid | output | 1 | Reply to the requester valid |
| rpl_pid | output | PW | Processor the reply is for |
| rpl_excl | output | 1 | 1 = exclusive grant, 0 = shared grant |
| rpl_data | output | DW | Line data for the requester |

## Verification
The assertions check several rules on every cycle. No reply leaves while a targeted response is outstanding. A recall always targets exactly one processor. An invalidate never targets the requester. Each counted response retires its pending bit. Any modified entry written to the directory has exactly one present processor. An acceptance always drops req_ready. Other behaviour shows only across the bench's request sequences: presence bits build up over several reads, ownership passes from one writer to the next, and written-back data later reaches clean readers. The bench also injects a stray response and checks that it does not release a reply early.

// File: rtl/dir_pkg.sv
package dir_pkg;
  localparam logic [1:0] MSG_NONE      = 2'd0;
  localparam logic [1:0] MSG_RECALL_SH = 2'd1;
  localparam logic [1:0] MSG_RECALL_IV = 2'd2;
  localparam logic [1:0] MSG_INVAL     = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_REPLY = 2'd3
  } seq_state_t;
endpackage

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(NBLK)-1:0]  rd_blk,
  output logic [NPROC-1:0]         rd_pres,
  output logic                     rd_dirty,
  output logic [DW-1:0]            rd_data,
  input  logic                     dir_we,
  input  logic [$clog2(NBLK)-1:0]  wr_blk,
  input  logic [NPROC-1:0]         wr_pres,
  input  logic                     wr_dirty,
  input  logic                     mem_we,
  input  logic [DW-1:0]            mem_wdata
);
  logic [NPROC-1:0] pres_q  [NBLK];
  logic             dirty_q [NBLK];
  logic [DW-1:0]    mem_q   [NBLK];

  genvar b;
  generate
    for (b = 0; b < NBLK; b++) begin : g_blk
      logic sel;
      assign sel = (wr_blk == b[$clog2(NBLK)-1:0]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pres_q[b]  <= '0;
          dirty_q[b] <= 1'b0;
        end else if (dir_we && sel) begin
          pres_q[b]  <= wr_pres;
          dirty_q[b] <= wr_dirty;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[b] <= DW'(b + 16);
        end else if (mem_we && sel) begin
          mem_q[b] <= mem_wdata;
        end
      end
    end
  endgenerate

  assign rd_pres  = pres_q[rd_blk];
  assign rd_dirty = dirty_q[rd_blk];
  assign rd_data  = mem_q[rd_blk];

  AST_DIRTY_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && wr_dirty) |-> $onehot(wr_pres)); // R6
endmodule

// File: rtl/pend_tracker.sv
module pend_tracker #(
  parameter int NPROC = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [NPROC-1:0]          load_mask,
  input  logic                      rsp_valid,
  input  logic [$clog2(NPROC)-1:0]  rsp_pid,
  output logic [NPROC-1:0]          pending,
  output logic                      hit,
  output logic                      done_now
);
  logic [NPROC-1:0] pend_q, pend_d, rsp_bit;

  assign rsp_bit  = NPROC'(1) << rsp_pid;
  assign hit      = rsp_valid && pend_q[rsp_pid];
  assign done_now = hit && ((pend_q & ~rsp_bit) == '0);

  always_comb begin
    pend_d = pend_q;
    if (load)
      pend_d = load_mask;
    else if (hit)
      pend_d = pend_q & ~rsp_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;

  AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !load) |=> !pending[$past(rsp_pid)]); // R5
endmodule

// File: rtl/dir_seq.sv
module dir_seq
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [$clog2(NBLK)-1:0]   req_blk,
  input  logic [$clog2(NPROC)-1:0]  req_pid,
  input  logic [NPROC-1:0]          rd_pres,
  input  logic                      rd_dirty,
  input  logic [DW-1:0]             rd_data,
  output logic                      dir_we,
  output logic [$clog2(NBLK)-1:0]   wr_blk,
  output logic [NPROC-1:0]          wr_pres,
  output logic                      wr_dirty,
  output logic                      mem_we,
  output logic [DW-1:0]             mem_wdata,
  output logic                      msg_valid,
  output logic [1:0]                msg_type,
  output logic [NPROC-1:0]          msg_dst,
  input  logic [DW-1:0]             rsp_data,
  output logic                      trk_load,
  output logic [NPROC-1:0]          trk_mask,
  input  logic                      trk_hit,
  input  logic                      trk_done,
  output logic                      rpl_valid,
  output logic [$clog2(NPROC)-1:0]  rpl_pid,
  output logic                      rpl_excl,
  output logic [DW-1:0]             rpl_data
);
  localparam int BW = $clog2(NBLK);
  localparam int PW = $clog2(NPROC);

  seq_state_t         st_q, st_d;
  logic [BW-1:0]      blk_q;
  logic [PW-1:0]      pid_q;
  logic               wr_q;
  logic [1:0]         kind_q, kind_d;
  logic [NPROC-1:0]   mask_q, mask_d;
  logic [NPROC-1:0]   pres_q;
  logic [DW-1:0]      data_q, data_d;
  logic               acc, cap_rsp, recall_q;
  logic [NPROC-1:0]   req_bit, own_bit, others;

  assign req_ready = (st_q == ST_IDLE);
  assign acc       = req_ready && req_valid;
  assign req_bit   = NPROC'(1) << req_pid;
  assign own_bit   = NPROC'(1) << pid_q;
  assign others    = rd_pres & ~req_bit;
  assign recall_q  = (kind_q == MSG_RECALL_SH) || (kind_q == MSG_RECALL_IV);
  assign cap_rsp   = (st_q == ST_WAIT) && trk_hit && recall_q;

  // next-state and capture decisions
  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    mask_d = mask_q;
    data_d = data_q;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          data_d = rd_data;
          if (rd_dirty && others != '0) begin
            kind_d = req_write ? MSG_RECALL_IV : MSG_RECALL_SH;
            mask_d = others;
            st_d   = ST_SEND;
          end else if (!rd_dirty && req_write && others != '0) begin
            kind_d = MSG_INVAL;
            mask_d = others;
            st_d   = ST_SEND;
          end else begin
            kind_d = MSG_NONE;
            mask_d = '0;
            st_d   = ST_REPLY;
          end
        end
      end
      ST_SEND:  st_d = ST_WAIT;
      ST_WAIT: begin
        if (cap_rsp) data_d = rsp_data;
        if (trk_done) st_d = ST_REPLY;
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q  <= '0;
      pid_q  <= '0;
      wr_q   <= 1'b0;
      kind_q <= MSG_NONE;
      mask_q <= '0;
      pres_q <= '0;
    end else if (acc) begin
      blk_q  <= req_blk;
      pid_q  <= req_pid;
      wr_q   <= req_write;
      kind_q <= kind_d;
      mask_q <= mask_d;
      pres_q <= rd_pres;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             data_q <= '0;
    else if (acc || cap_rsp) data_q <= data_d;
  end

  // outbound message and response tracking
  assign msg_valid = (st_q == ST_SEND);
  assign msg_type  = msg_valid ? kind_q : MSG_NONE;
  assign msg_dst   = msg_valid ? mask_q : '0;
  assign trk_load  = msg_valid;
  assign trk_mask  = mask_q;

  // directory and memory update at completion
  assign dir_we    = (st_q == ST_REPLY);
  assign wr_blk    = blk_q;
  assign wr_pres   = wr_q ? own_bit : (pres_q | own_bit);
  assign wr_dirty  = wr_q;
  assign mem_we    = (st_q == ST_REPLY) && recall_q;
  assign mem_wdata = data_q;

  assign rpl_valid = (st_q == ST_REPLY);
  assign rpl_pid   = pid_q;
  assign rpl_excl  = wr_q;
  assign rpl_data  = data_q;

  AST_STALL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R8
  AST_INVAL_SKIPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((msg_dst & own_bit) == '0)); // R4
  AST_MSG_TYPED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_type != MSG_NONE && msg_dst != '0)); // R9
  AST_RECALL_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type != MSG_INVAL) |-> $onehot(msg_dst)); // R3
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl #(
  parameter int NPROC = 4,
  parameter int NBLK  = 8,
  parameter int DW    = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [$clog2(NBLK)-1:0]   req_blk,
  input  logic [$clog2(NPROC)-1:0]  req_pid,
  output logic                      msg_valid,
  output logic [1:0]                msg_type,
  output logic [NPROC-1:0]          msg_dst,
  input  logic                      rsp_valid,
  input  logic [$clog2(NPROC)-1:0]  rsp_pid,
  input  logic [DW-1:0]             rsp_data,
  output logic                      rpl_valid,
  output logic [$clog2(NPROC)-1:0]  rpl_pid,
  output logic                      rpl_excl,
  output logic [DW-1:0]             rpl_data
);
  localparam int BW = $clog2(NBLK);

  logic [NPROC-1:0] rd_pres, wr_pres, trk_mask, pending;
  logic             rd_dirty, wr_dirty, dir_we, mem_we;
  logic [DW-1:0]    rd_data, mem_wdata;
  logic [BW-1:0]    wr_blk;
  logic             trk_load, trk_hit, trk_done;

  dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_blk(req_blk), .rd_pres(rd_pres), .rd_dirty(rd_dirty), .rd_data(rd_data),
    .dir_we(dir_we), .wr_blk(wr_blk), .wr_pres(wr_pres), .wr_dirty(wr_dirty),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  pend_tracker #(.NPROC(NPROC)) u_trk (
    .clk(clk), .rst_n(rst_n),
    .load(trk_load), .load_mask(trk_mask),
    .rsp_valid(rsp_valid), .rsp_pid(rsp_pid),
    .pending(pending), .hit(trk_hit), .done_now(trk_done)
  );

  dir_seq #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_blk(req_blk), .req_pid(req_pid),
    .rd_pres(rd_pres), .rd_dirty(rd_dirty), .rd_data(rd_data),
    .dir_we(dir_we), .wr_blk(wr_blk), .wr_pres(wr_pres), .wr_dirty(wr_dirty),
    .mem_we(mem_we), .mem_wdata(mem_wdata),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_dst(msg_dst),
    .rsp_data(rsp_data),
    .trk_load(trk_load), .trk_mask(trk_mask), .trk_hit(trk_hit), .trk_done(trk_done),
    .rpl_valid(rpl_valid), .rpl_pid(rpl_pid), .rpl_excl(rpl_excl), .rpl_data(rpl_data)
  );

  AST_REPLY_AFTER_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid |-> (pending == '0)); // R5
endmodule

// File: tb/tb_dir_ctrl.sv
module tb_dir_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [2:0]  req_blk = '0;
  logic [1:0]  req_pid = '0;
  logic        req_ready, msg_valid, rpl_valid, rpl_excl;
  logic [1:0]  msg_type, rpl_pid;
  logic [3:0]  msg_dst;
  logic        rsp_valid = 1'b0;
  logic [1:0]  rsp_pid = '0;
  logic [31:0] rsp_data = '0, rpl_data;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  dir_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_blk(req_blk), .req_pid(req_pid),
    .msg_valid(msg_valid), .msg_type(msg_type), .msg_dst(msg_dst),
    .rsp_valid(rsp_valid), .rsp_pid(rsp_pid), .rsp_data(rsp_data),
    .rpl_valid(rpl_valid), .rpl_pid(rpl_pid), .rpl_excl(rpl_excl), .rpl_data(rpl_data)
  );

  typedef struct packed {
    logic        w;
    logic [2:0]  blk;
    logic [1:0]  pid;
    logic [1:0]  et;
    logic [3:0]  ed;
    logic [31:0] rdat;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{1'b0, 3'd2, 2'd0, 2'd0, 4'b0000, 32'h0,  32'h12}, // R2
    '{1'b0, 3'd2, 2'd1, 2'd0, 4'b0000, 32'h0,  32'h12}, // R2
    '{1'b1, 3'd2, 2'd2, 2'd3, 4'b0011, 32'h0,  32'h12}, // R4
    '{1'b0, 3'd2, 2'd3, 2'd1, 4'b0100, 32'hAB, 32'hAB}, // R3 R6
    '{1'b0, 3'd2, 2'd0, 2'd0, 4'b0000, 32'h0,  32'hAB}, // R3 write-back
    '{1'b1, 3'd2, 2'd3, 2'd3, 4'b0101, 32'h0,  32'hAB}, // R4 owner kept present
    '{1'b1, 3'd2, 2'd1, 2'd2, 4'b1000, 32'hCD, 32'hCD}, // R7
    '{1'b1, 3'd5, 2'd1, 2'd0, 4'b0000, 32'h0,  32'h15}, // R4 no sharers
    '{1'b0, 3'd5, 2'd0, 2'd1, 4'b0010, 32'h77, 32'h77}, // R3 R6
    '{1'b1, 3'd5, 2'd0, 2'd3, 4'b0010, 32'h0,  32'h77}, // R4
    '{1'b0, 3'd3, 2'd0, 2'd0, 4'b0000, 32'h0,  32'h13}, // R1 R2
    '{1'b0, 3'd3, 2'd1, 2'd0, 4'b0000, 32'h0,  32'h13}  // R2
  };

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [2:0] blk, input logic [1:0] pid);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_blk = blk; req_pid = pid;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    logic [1:0] mt = 2'd0;
    logic [3:0] md = 4'd0;
    bit done = 0;
    issue(v.w, v.blk, v.pid);
    for (int c = 0; c < 40 && !done; c++) begin
      if (rpl_valid) begin
        done = 1;
        check(mt == v.et, $sformatf("R3/R4/R7 type vec%0d", idx), 32'(mt), 32'(v.et));
        check(md == v.ed, $sformatf("R4 dst vec%0d", idx), 32'(md), 32'(v.ed));
        check(rpl_data == v.exp, $sformatf("R2/R3 data vec%0d", idx), rpl_data, v.exp);
        check(rpl_excl == v.w && rpl_pid == v.pid, $sformatf("R9 vec%0d", idx),
              {rpl_excl, 2'b0, rpl_pid}, {v.w, 2'b0, v.pid});
        check(req_ready == 1'b0, $sformatf("R8 busy vec%0d", idx), 32'(req_ready), 0);
      end else if (msg_valid) begin
        mt = msg_type; md = msg_dst;
        @(negedge clk);
        for (int b = 0; b < 4; b++) begin
          if (md[b]) begin
            rsp_valid = 1'b1; rsp_pid = 2'(b); rsp_data = v.rdat;
            @(negedge clk);
          end
        end
        rsp_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check(done, $sformatf("R5 reply seen vec%0d", idx), 32'(done), 1);
    @(negedge clk);
    check(req_ready == 1'b1, $sformatf("R8 ready vec%0d", idx), 32'(req_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready && !msg_valid && !rpl_valid, "R1 idle after reset",
          {req_ready, msg_valid, rpl_valid}, 32'b100);

    for (int i = 0; i < 12; i++) run_vec(TBL[i], i);

    // R5: partial acks and a stray response must not release the reply
    issue(1'b1, 3'd3, 2'd2);
    check(msg_valid && msg_type == 2'd3 && msg_dst == 4'b0011, "R4 inval blk3",
          {msg_valid, msg_type, msg_dst}, {1'b1, 2'd3, 4'b0011});
    @(negedge clk);
    rsp_valid = 1'b1; rsp_pid = 2'd0; @(negedge clk);
    rsp_pid = 2'd3; @(negedge clk);
    rsp_valid = 1'b0;
    check(!rpl_valid, "R5 stray response ignored", 32'(rpl_valid), 0);
    @(negedge clk);
    check(!rpl_valid, "R5 still waiting", 32'(rpl_valid), 0);
    rsp_valid = 1'b1; rsp_pid = 2'd1; @(negedge clk);
    rsp_valid = 1'b0;
    check(rpl_valid && rpl_excl && rpl_data == 32'h13, "R5 reply after last ack",
          {rpl_valid, rpl_excl, rpl_data[29:0]}, {2'b11, 30'h13});
    @(negedge clk);

    // R6: requester is sole owner, next reader recalls from p2 only
    issue(1'b0, 3'd3, 2'd1);
    check(msg_valid && msg_type == 2'd1 && msg_dst == 4'b0100, "R6 sole owner",
          {msg_type, msg_dst}, {2'd1, 4'b0100});
    @(negedge clk);
    rsp_valid = 1'b1; rsp_pid = 2'd2; rsp_data = 32'h5A; @(negedge clk);
    rsp_valid = 1'b0;
    check(rpl_valid && rpl_data == 32'h5A && !rpl_excl, "R3 recalled data", rpl_data, 32'h5A);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule